// File: doc/BRIEF.md
# Fuse Bit Programming Engine with Region Lock Map

This block drives a one-time-programmable fuse macro of 512 bytes. After reset it brings the macro up through a two-step power handshake. It then copies the macro's lock bitmap into a shadow register and starts taking commands. A read command fetches one byte. A write command programs a run of bytes inside the user-writable region. Each byte is programmed with only the bits that are not yet blown, so a fuse is never pulsed twice.

Every write goes through a gate before any byte is touched. The gate requires a key that was stored beforehand, and the key is used up by the attempt. The range must sit inside the user region and be word aligned. No 4-byte word in the range may already be locked. After the data is in, the engine sets the lock bits for the written words in the shadow map. It then burns the bitmap bytes at the top of the array with the same only-new-bits rule. Write data is pulled from the requester one byte at a time through an index and byte pair.

Top module: `otp_prog_engine`

## Requirements
- R1: After reset the engine drives `mac_ceb` low and waits for `mac_st[0]`. Only then does it drive `mac_rstb` high and wait for `mac_st[2]`. It then reads the 8 lock-map bytes at 0x1F8..0x1FF into its shadow and raises `init_done`. No program strobe occurs before `init_done`. During reset `mac_ceb`=1, `mac_rstb`=0 and `init_done`=0.
- R2: A `rd_start` pulse in idle reads the byte at `rd_addr` through the macro read port. It ends with a one-cycle `done`, `status`=0 and the byte on `rd_data`.
- R3: Each programmed byte uses bit address = byte address × 8, length field 7 (length minus one) and data = requested byte AND NOT current fuse byte. A byte whose result is zero is not programmed.
- R4: A write is refused with `status`=1 unless the unlock register holds 0x524F434B. Any write attempt made in idle clears that register, whether the write is accepted or refused.
- R5: A write is refused with `status`=2 in any of these cases: the offset is below 0x100, offset+length exceeds 0x1F0, the length is zero, or the offset or length is not a multiple of 4.
- R6: Lock bit k lives in byte 0x1F8+k/8, bit k%8, and covers bytes 0x100+4k..0x103+4k. After all data bytes of an accepted write are done, the bits for the written words are set in the shadow. The bitmap bytes are then programmed under the R3 rule.
- R7: A write covering any word whose lock bit is set is refused with `status`=3 and programs nothing. This includes bits loaded from the array at start-up. The checks rank R4 first, then R5, then R7.
- R8: If the macro's busy flag stays high for `TMO_CYCLES` cycles during a read or program wait of a command, the command ends with `status`=4 and the lock map is not updated.
- R9: Each command ends with exactly one one-cycle `done`. `wr_start` and `rd_start` are ignored while `busy` is high. A `wr_start` and a `rd_start` in the same idle cycle start the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_we | input | 1 | Store `unlock_val` in the unlock register |
| unlock_val | input | 32 | Unlock key value |
| wr_start | input | 1 | Start a write command |
| wr_off | input | 9 | Write byte offset |
| wr_len | input | 9 | Write length in bytes |
| src_idx | output | 9 | Index of the write byte wanted |
| src_byte | input | 8 | Write byte at `src_idx` (combinational) |
| rd_start | input | 1 | Start a byte read |
| rd_addr | input | 9 | Read byte address |
| rd_data | output | 8 | Byte returned by the last read |
| init_done | output | 1 | Handshake and map load complete |
| busy | output | 1 | Command or start-up sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 3 | Result: 0 ok, 1 locked, 2 bad range, 3 protected, 4 timeout |
| mac_ceb | output | 1 | Macro chip enable, active low |
| mac_rstb | output | 1 | Macro reset release, active high |
| mac_st | input | 3 | Macro status; bit 0 enabled, bit 2 out of reset |
| mac_raddr | output | 9 | Macro read byte address |
| mac_rstart | output | 1 | Macro read strobe |
| mac_rbusy | input | 1 | Macro read in progress |
| mac_rdata | input | 8 | Macro read data |
| mac_pbit | output | 12 | Macro program bit address |
| mac_plen | output | 3 | Macro program length minus one |
| mac_pdata | output | 8 | Macro program data |
| mac_pstart | output | 1 | Macro program strobe |
| mac_pbusy | input | 1 | Macro program in progress |

## Verification
The hardest case to reach from the ports is a lock bit that no write in the run has set. It must come from the array itself at start-up. The bench model seeds the fuse byte at 0x1FF while reset is still held. It then shows that a write to the matching top word is refused after `init_done`. A second hard case is a write that only partly overlaps a locked word; the bench covers it with a two-word write whose second word is locked. The only-new-bits rule is reached by setting some bits of a target byte behind the engine's back before a write. The bench model counts any program pulse that hits a bit already blown. The timeout is forced by stretching the model's program latency past the limit. The bench then shows that the late-landing data changed the array but the lock map did not change.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int OTP_AW     = 9;
    localparam int WORD_BYTES = 4;
    localparam int PBIT_W     = OTP_AW + 3;

    typedef logic [OTP_AW-1:0] baddr_t;

    typedef struct packed {
        baddr_t off;
        baddr_t len;
    } wr_req_t;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_LOCKED  = 3'd1,
        ST_BADARG  = 3'd2,
        ST_PROT    = 3'd3,
        ST_TIMEOUT = 3'd4
    } otp_status_e;

    typedef enum logic [3:0] {
        S_CE, S_RB, S_IDLE, S_RISSUE, S_RGAP, S_RWAIT,
        S_PISSUE, S_PGAP, S_PWAIT, S_NEXT, S_FINISH
    } otp_state_e;

    typedef enum logic [1:0] {
        PH_LOAD, PH_USER, PH_DATA, PH_MAP
    } otp_phase_e;

    function automatic logic word_aligned(baddr_t v);
        return v[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/otp_wr_guard.sv
module otp_wr_guard
    import otp_pkg::*;
#(
    parameter int          OEM_BASE  = 256,
    parameter int          OEM_BYTES = 240,
    parameter int          MAP_BITS  = 64,
    parameter logic [31:0] KEY       = 32'h524F434B
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                unlock_we,
    input  logic [31:0]         unlock_val,
    input  logic                consume,
    input  wr_req_t             live_req,
    input  wr_req_t             held_req,
    input  logic [MAP_BITS-1:0] map_bits,
    output otp_status_e         verdict,
    output logic [MAP_BITS-1:0] held_span
);

    localparam int LIMIT = OEM_BASE + OEM_BYTES;

    logic [31:0]         key_q;
    logic                unlocked;
    logic                in_range;
    logic                aligned;
    logic [MAP_BITS-1:0] live_span;

    function automatic logic [MAP_BITS-1:0] span_of(wr_req_t r);
        logic [MAP_BITS-1:0] m;
        int lo;
        int hi;
        int w;
        lo = int'(r.off);
        hi = int'(r.off) + int'(r.len);
        for (int k = 0; k < MAP_BITS; k++) begin
            w    = OEM_BASE + WORD_BYTES * k;
            m[k] = (w >= lo) && (w < hi);
        end
        return m;
    endfunction

    always_ff @(posedge clk) begin
        if (rst)
            key_q <= '0;
        else if (consume)
            key_q <= '0;
        else if (unlock_we)
            key_q <= unlock_val;
    end

    assign unlocked  = (key_q == KEY);
    assign live_span = span_of(live_req);
    assign held_span = span_of(held_req);

    always_comb begin
        int lo;
        int hi;
        lo       = int'(live_req.off);
        hi       = int'(live_req.off) + int'(live_req.len);
        in_range = (lo >= OEM_BASE) && (hi <= LIMIT) && (live_req.len != '0);
        aligned  = word_aligned(live_req.off) && word_aligned(live_req.len);
    end

    always_comb begin
        if (!unlocked)
            verdict = ST_LOCKED;
        else if (!in_range || !aligned)
            verdict = ST_BADARG;
        else if ((live_span & map_bits) != '0)
            verdict = ST_PROT;
        else
            verdict = ST_OK;
    end

    AST_UNLOCK_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        consume |=> verdict == ST_LOCKED); // R4

endmodule

// File: rtl/otp_prot_map.sv
module otp_prot_map #(
    parameter int MAP_BYTES = 8,
    parameter int IDX_W     = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1,
    parameter int MAP_BITS  = MAP_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [IDX_W-1:0]    load_idx,
    input  logic [7:0]          load_byte,
    input  logic                set_en,
    input  logic [MAP_BITS-1:0] set_mask,
    input  logic [IDX_W-1:0]    sel_idx,
    output logic [MAP_BITS-1:0] map_bits,
    output logic [7:0]          sel_byte
);

    logic [MAP_BYTES-1:0][7:0] bytes_q;

    for (genvar g = 0; g < MAP_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                bytes_q[g] <= '0;
            else if (load_en && load_idx == IDX_W'(g))
                bytes_q[g] <= load_byte;
            else if (set_en)
                bytes_q[g] <= bytes_q[g] | set_mask[g*8 +: 8];
        end
    end

    assign map_bits = bytes_q;
    assign sel_byte = bytes_q[sel_idx];

    AST_MAP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (map_bits & $past(map_bits)) == $past(map_bits)); // R6

endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int OEM_BASE   = 256,
    parameter int OEM_BYTES  = 240,
    parameter int MAP_BASE   = 504,
    parameter int MAP_BYTES  = 8,
    parameter int TMO_CYCLES = 1000,
    parameter int IDX_W      = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1,
    parameter int TMO_W      = $clog2(TMO_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  wr_req_t           live_req,
    input  logic              rd_start,
    input  baddr_t            rd_addr,
    input  otp_status_e       verdict,
    output logic              consume,
    output wr_req_t           held_req,
    output baddr_t            src_idx,
    input  logic [7:0]        src_byte,
    output logic              load_en,
    output logic [IDX_W-1:0]  map_idx,
    output logic              set_en,
    input  logic [7:0]        map_byte,
    output logic [7:0]        rd_data,
    output logic              init_done,
    output logic              busy,
    output logic              done,
    output otp_status_e       status,
    output logic              mac_ceb,
    output logic              mac_rstb,
    input  logic [2:0]        mac_st,
    output baddr_t            mac_raddr,
    output logic              mac_rstart,
    input  logic              mac_rbusy,
    input  logic [7:0]        mac_rdata,
    output logic [PBIT_W-1:0] mac_pbit,
    output logic [2:0]        mac_plen,
    output logic [7:0]        mac_pdata,
    output logic              mac_pstart,
    input  logic              mac_pbusy
);

    localparam logic [IDX_W-1:0] MAP_LAST = IDX_W'(MAP_BYTES - 1);

    otp_state_e       state;
    otp_phase_e       phase;
    baddr_t           addr;
    baddr_t           cnt;
    logic [7:0]       pdata_q;
    logic [TMO_W-1:0] tmo;
    logic [7:0]       cand;
    logic             data_last;
    logic             tmo_hit;

    assign consume   = (state == S_IDLE) && wr_start;
    assign cand      = ((phase == PH_MAP) ? map_byte : src_byte) & ~mac_rdata;
    assign data_last = (cnt == held_req.len - 1'b1);
    assign tmo_hit   = (tmo == TMO_W'(TMO_CYCLES - 1));
    assign load_en   = (state == S_RWAIT) && (phase == PH_LOAD) && !mac_rbusy;
    assign set_en    = (state == S_NEXT) && (phase == PH_DATA) && data_last;
    assign src_idx   = cnt;
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_FINISH);
    assign mac_raddr = addr;
    assign mac_pbit  = {addr, 3'b000};
    assign mac_plen  = 3'd7;
    assign mac_pdata = pdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_CE;
            phase      <= PH_LOAD;
            addr       <= '0;
            cnt        <= '0;
            map_idx    <= '0;
            held_req   <= '0;
            pdata_q    <= '0;
            tmo        <= '0;
            rd_data    <= '0;
            init_done  <= 1'b0;
            status     <= ST_OK;
            mac_ceb    <= 1'b1;
            mac_rstb   <= 1'b0;
            mac_rstart <= 1'b0;
            mac_pstart <= 1'b0;
        end else begin
            case (state)
                S_CE: begin
                    mac_ceb <= 1'b0;
                    if (!mac_ceb && mac_st[0]) begin
                        mac_rstb <= 1'b1;
                        state    <= S_RB;
                    end
                end
                S_RB: begin
                    if (mac_st[2]) begin
                        phase   <= PH_LOAD;
                        addr    <= baddr_t'(MAP_BASE);
                        map_idx <= '0;
                        state   <= S_RISSUE;
                    end
                end
                S_IDLE: begin
                    if (wr_start) begin
                        held_req <= live_req;
                        status   <= verdict;
                        if (verdict != ST_OK) begin
                            state <= S_FINISH;
                        end else begin
                            phase <= PH_DATA;
                            addr  <= live_req.off;
                            cnt   <= '0;
                            state <= S_RISSUE;
                        end
                    end else if (rd_start) begin
                        status <= ST_OK;
                        phase  <= PH_USER;
                        addr   <= rd_addr;
                        state  <= S_RISSUE;
                    end
                end
                S_RISSUE: begin
                    mac_rstart <= 1'b1;
                    tmo        <= '0;
                    state      <= S_RGAP;
                end
                S_RGAP: begin
                    mac_rstart <= 1'b0;
                    state      <= S_RWAIT;
                end
                S_RWAIT: begin
                    if (!mac_rbusy) begin
                        case (phase)
                            PH_LOAD: begin
                                if (map_idx == MAP_LAST) begin
                                    init_done <= 1'b1;
                                    state     <= S_IDLE;
                                end else begin
                                    map_idx <= map_idx + 1'b1;
                                    addr    <= addr + 1'b1;
                                    state   <= S_RISSUE;
                                end
                            end
                            PH_USER: begin
                                rd_data <= mac_rdata;
                                state   <= S_FINISH;
                            end
                            default: begin
                                pdata_q <= cand;
                                state   <= (cand != '0) ? S_PISSUE : S_NEXT;
                            end
                        endcase
                    end else if (phase != PH_LOAD) begin
                        tmo <= tmo + 1'b1;
                        if (tmo_hit) begin
                            status <= ST_TIMEOUT;
                            state  <= S_FINISH;
                        end
                    end
                end
                S_PISSUE: begin
                    mac_pstart <= 1'b1;
                    tmo        <= '0;
                    state      <= S_PGAP;
                end
                S_PGAP: begin
                    mac_pstart <= 1'b0;
                    state      <= S_PWAIT;
                end
                S_PWAIT: begin
                    if (!mac_pbusy) begin
                        state <= S_NEXT;
                    end else begin
                        tmo <= tmo + 1'b1;
                        if (tmo_hit) begin
                            status <= ST_TIMEOUT;
                            state  <= S_FINISH;
                        end
                    end
                end
                S_NEXT: begin
                    if (phase == PH_DATA) begin
                        if (data_last) begin
                            phase   <= PH_MAP;
                            addr    <= baddr_t'(MAP_BASE);
                            map_idx <= '0;
                        end else begin
                            cnt  <= cnt + 1'b1;
                            addr <= addr + 1'b1;
                        end
                        state <= S_RISSUE;
                    end else if (map_idx == MAP_LAST) begin
                        state <= S_FINISH;
                    end else begin
                        map_idx <= map_idx + 1'b1;
                        addr    <= addr + 1'b1;
                        state   <= S_RISSUE;
                    end
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    AST_NO_PROG_EARLY: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !mac_pstart); // R1

    AST_RSTB_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
        mac_rstb |-> !mac_ceb); // R1

    AST_PDATA_NONZERO: assert property (@(posedge clk) disable iff (rst)
        mac_pstart |-> mac_pdata != 8'h00); // R3

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mac_rstart && mac_pstart)); // R3

    AST_PROG_REGION: assert property (@(posedge clk) disable iff (rst)
        mac_pstart |-> ((int'(mac_raddr) >= OEM_BASE && int'(mac_raddr) < OEM_BASE + OEM_BYTES)
                     || (int'(mac_raddr) >= MAP_BASE && int'(mac_raddr) < MAP_BASE + MAP_BYTES))); // R6

    AST_REFUSE_FAST: assert property (@(posedge clk) disable iff (rst)
        (consume && verdict != ST_OK) |=> (done && !mac_rstart)); // R7

    AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R9

endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine
    import otp_pkg::*;
#(
    parameter int          OEM_BASE   = 256,
    parameter int          OEM_BYTES  = 240,
    parameter int          MAP_BASE   = 504,
    parameter int          MAP_BYTES  = 8,
    parameter int          TMO_CYCLES = 1000,
    parameter logic [31:0] KEY        = 32'h524F434B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock_we,
    input  logic [31:0]       unlock_val,
    input  logic              wr_start,
    input  logic [8:0]        wr_off,
    input  logic [8:0]        wr_len,
    output logic [8:0]        src_idx,
    input  logic [7:0]        src_byte,
    input  logic              rd_start,
    input  logic [8:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              init_done,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status,
    output logic              mac_ceb,
    output logic              mac_rstb,
    input  logic [2:0]        mac_st,
    output logic [8:0]        mac_raddr,
    output logic              mac_rstart,
    input  logic              mac_rbusy,
    input  logic [7:0]        mac_rdata,
    output logic [11:0]       mac_pbit,
    output logic [2:0]        mac_plen,
    output logic [7:0]        mac_pdata,
    output logic              mac_pstart,
    input  logic              mac_pbusy
);

    localparam int MAP_BITS = MAP_BYTES * 8;
    localparam int IDX_W    = (MAP_BYTES > 1) ? $clog2(MAP_BYTES) : 1;

    wr_req_t             live_req;
    wr_req_t             held_req;
    otp_status_e         verdict;
    otp_status_e         status_e;
    logic                consume;
    logic [MAP_BITS-1:0] map_bits;
    logic [MAP_BITS-1:0] held_span;
    logic                load_en;
    logic                set_en;
    logic [IDX_W-1:0]    map_idx;
    logic [7:0]          map_byte;

    assign live_req.off = wr_off;
    assign live_req.len = wr_len;
    assign status       = status_e;

    otp_wr_guard #(
        .OEM_BASE (OEM_BASE),
        .OEM_BYTES(OEM_BYTES),
        .MAP_BITS (MAP_BITS),
        .KEY      (KEY)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .unlock_we (unlock_we),
        .unlock_val(unlock_val),
        .consume   (consume),
        .live_req  (live_req),
        .held_req  (held_req),
        .map_bits  (map_bits),
        .verdict   (verdict),
        .held_span (held_span)
    );

    otp_prot_map #(
        .MAP_BYTES(MAP_BYTES),
        .IDX_W    (IDX_W),
        .MAP_BITS (MAP_BITS)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_idx (map_idx),
        .load_byte(mac_rdata),
        .set_en   (set_en),
        .set_mask (held_span),
        .sel_idx  (map_idx),
        .map_bits (map_bits),
        .sel_byte (map_byte)
    );

    otp_seq #(
        .OEM_BASE  (OEM_BASE),
        .OEM_BYTES (OEM_BYTES),
        .MAP_BASE  (MAP_BASE),
        .MAP_BYTES (MAP_BYTES),
        .TMO_CYCLES(TMO_CYCLES),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_start  (wr_start),
        .live_req  (live_req),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .verdict   (verdict),
        .consume   (consume),
        .held_req  (held_req),
        .src_idx   (src_idx),
        .src_byte  (src_byte),
        .load_en   (load_en),
        .map_idx   (map_idx),
        .set_en    (set_en),
        .map_byte  (map_byte),
        .rd_data   (rd_data),
        .init_done (init_done),
        .busy      (busy),
        .done      (done),
        .status    (status_e),
        .mac_ceb   (mac_ceb),
        .mac_rstb  (mac_rstb),
        .mac_st    (mac_st),
        .mac_raddr (mac_raddr),
        .mac_rstart(mac_rstart),
        .mac_rbusy (mac_rbusy),
        .mac_rdata (mac_rdata),
        .mac_pbit  (mac_pbit),
        .mac_plen  (mac_plen),
        .mac_pdata (mac_pdata),
        .mac_pstart(mac_pstart),
        .mac_pbusy (mac_pbusy)
    );

endmodule

// File: tb/tb_otp_prog_engine.sv
`timescale 1ns/1ps
module tb_otp_prog_engine;

    localparam logic [31:0] KEY = 32'h524F434B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock_we = 1'b0;
    logic [31:0] unlock_val = '0;
    logic        wr_start = 1'b0;
    logic [8:0]  wr_off = '0;
    logic [8:0]  wr_len = '0;
    logic [8:0]  src_idx;
    logic [7:0]  src_byte;
    logic        rd_start = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        init_done, busy, done;
    logic [2:0]  status;
    logic        mac_ceb, mac_rstb, mac_rstart, mac_pstart;
    logic [2:0]  mac_st;
    logic [8:0]  mac_raddr;
    logic        mac_rbusy = 1'b0;
    logic        mac_pbusy = 1'b0;
    logic [7:0]  mac_rdata = '0;
    logic [11:0] mac_pbit;
    logic [2:0]  mac_plen;
    logic [7:0]  mac_pdata;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    otp_prog_engine dut (
        .clk(clk), .rst(rst), .unlock_we(unlock_we), .unlock_val(unlock_val),
        .wr_start(wr_start), .wr_off(wr_off), .wr_len(wr_len),
        .src_idx(src_idx), .src_byte(src_byte),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_data(rd_data),
        .init_done(init_done), .busy(busy), .done(done), .status(status),
        .mac_ceb(mac_ceb), .mac_rstb(mac_rstb), .mac_st(mac_st),
        .mac_raddr(mac_raddr), .mac_rstart(mac_rstart), .mac_rbusy(mac_rbusy),
        .mac_rdata(mac_rdata), .mac_pbit(mac_pbit), .mac_plen(mac_plen),
        .mac_pdata(mac_pdata), .mac_pstart(mac_pstart), .mac_pbusy(mac_pbusy)
    );

    // ---------------- fuse macro model ----------------
    logic [7:0] fuse [0:511] = '{default: 8'h00};
    logic [7:0] wbuf [0:255] = '{default: 8'h00};
    int   plat = 5;
    int   rlat = 3;
    int   prog_cnt = 0;
    int   viol_cnt = 0;
    int   fmt_cnt  = 0;
    int   order_err = 0;
    int   ce_cnt = 0, rb_cnt = 0, rcnt = 0, pcnt = 0;
    logic [8:0] ra_q = '0, pa_q = '0;
    logic [7:0] pd_q = '0;
    logic       poke_en = 1'b0;
    logic [8:0] poke_addr = '0;
    logic [7:0] poke_val = '0;
    logic       st0, st2;

    assign st0      = (ce_cnt == 4);
    assign st2      = (rb_cnt == 4) && st0;
    assign mac_st   = {st2, 1'b0, st0};
    assign src_byte = wbuf[src_idx[7:0]];

    always @(posedge clk) begin
        if (poke_en) fuse[poke_addr] <= poke_val;
        if (mac_ceb) ce_cnt <= 0; else if (ce_cnt < 4) ce_cnt <= ce_cnt + 1;
        if (!mac_rstb) rb_cnt <= 0; else if (rb_cnt < 4) rb_cnt <= rb_cnt + 1;
        if (mac_rstb && !st0) order_err <= order_err + 1;
        if (rst) begin
            mac_rbusy <= 1'b0;
            mac_pbusy <= 1'b0;
        end else begin
            if (mac_rstart) begin
                mac_rbusy <= 1'b1;
                rcnt      <= rlat;
                ra_q      <= mac_raddr;
            end else if (mac_rbusy) begin
                if (rcnt <= 1) begin
                    mac_rbusy <= 1'b0;
                    mac_rdata <= fuse[ra_q];
                end else rcnt <= rcnt - 1;
            end
            if (mac_pstart) begin
                mac_pbusy <= 1'b1;
                pcnt      <= plat;
                pa_q      <= mac_pbit[11:3];
                pd_q      <= mac_pdata;
                prog_cnt  <= prog_cnt + 1;
                if ((mac_pdata & fuse[mac_pbit[11:3]]) != 0) viol_cnt <= viol_cnt + 1;
                if (mac_plen != 3'd7 || mac_pbit[2:0] != 3'd0) fmt_cnt <= fmt_cnt + 1;
            end else if (mac_pbusy) begin
                if (pcnt <= 1) begin
                    mac_pbusy <= 1'b0;
                    fuse[pa_q] <= fuse[pa_q] | pd_q;
                end else pcnt <= pcnt - 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 9'(a); poke_val = 8'(v);
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic unlock(input logic [31:0] v);
        @(negedge clk);
        unlock_we = 1'b1; unlock_val = v;
        @(negedge clk);
        unlock_we = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "R9 done never seen", 0, 1);
    endtask

    task automatic do_write(input int off, input int len, output int st, output int cyc);
        @(negedge clk);
        wr_off = 9'(off); wr_len = 9'(len); wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        wait_done(cyc);
        st = int'(status);
        @(negedge clk);
    endtask

    task automatic do_read(input int a, output int val);
        int cyc;
        @(negedge clk);
        rd_addr = 9'(a); rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        wait_done(cyc);
        chk(status == 3'd0, "R2 read status", int'(status), 0);
        val = int'(rd_data);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_init();
        int cyc;
        poke(9'h1FF, 8'h08);
        @(negedge clk);
        chk(mac_ceb == 1'b1, "R1 ceb high in reset", int'(mac_ceb), 1);
        chk(mac_rstb == 1'b0, "R1 rstb low in reset", int'(mac_rstb), 0);
        chk(init_done == 1'b0, "R1 init_done low in reset", int'(init_done), 0);
        rst = 1'b0;
        cyc = 0;
        while (!init_done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(init_done == 1'b1, "R1 init_done rises", int'(init_done), 1);
        chk(order_err == 0, "R1 rstb only after ceb status", order_err, 0);
        chk(prog_cnt == 0, "R1 nothing programmed at start", prog_cnt, 0);
    endtask

    task automatic t_write_basic();
        int st, cyc, p0;
        logic [7:0] d [8] = '{8'h5A, 8'h00, 8'hFF, 8'h81, 8'h01, 8'h02, 8'h04, 8'h08};
        for (int i = 0; i < 8; i++) wbuf[i] = d[i];
        unlock(KEY);
        p0 = prog_cnt;
        do_write(9'h100, 8, st, cyc);
        chk(st == 0, "R3 basic write status", st, 0);
        chk(prog_cnt - p0 == 8, "R3 zero byte skipped, map burned", prog_cnt - p0, 8);
        for (int i = 0; i < 8; i++)
            chk(fuse[9'h100 + i] == d[i], "R3 data byte landed", int'(fuse[9'h100 + i]), int'(d[i]));
        chk(fuse[9'h1F8] == 8'h03, "R6 map bits 0,1 burned", int'(fuse[9'h1F8]), 3);
    endtask

    task automatic t_andnot();
        int st, cyc, p0;
        poke(9'h120, 8'h0F);
        wbuf[0] = 8'hFF; wbuf[1] = 8'h0F; wbuf[2] = 8'h00; wbuf[3] = 8'hF0;
        unlock(KEY);
        p0 = prog_cnt;
        do_write(9'h120, 4, st, cyc);
        chk(st == 0, "R3 and-not write status", st, 0);
        chk(prog_cnt - p0 == 4, "R3 and-not program count", prog_cnt - p0, 4);
        chk(viol_cnt == 0, "R3 no blown bit re-pulsed", viol_cnt, 0);
        chk(fmt_cnt == 0, "R3 bit address and length field", fmt_cnt, 0);
        chk(fuse[9'h120] == 8'hFF, "R3 merged byte", int'(fuse[9'h120]), 8'hFF);
        chk(fuse[9'h1F9] == 8'h01, "R6 map word 8 burned", int'(fuse[9'h1F9]), 1);
    endtask

    task automatic t_zero_data();
        int st, cyc, p0;
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h00;
        unlock(KEY);
        p0 = prog_cnt;
        do_write(9'h160, 4, st, cyc);
        chk(st == 0, "R3 zero write status", st, 0);
        chk(prog_cnt - p0 == 1, "R3 zero data unprogrammed, map only", prog_cnt - p0, 1);
        chk(fuse[9'h1FB] == 8'h01, "R6 map word 24 burned", int'(fuse[9'h1FB]), 1);
    endtask

    task automatic t_locked_args();
        int st, cyc, p0;
        wbuf[0] = 8'hAA; wbuf[1] = 8'hAA; wbuf[2] = 8'hAA; wbuf[3] = 8'hAA;
        p0 = prog_cnt;
        do_write(9'h140, 4, st, cyc);
        chk(st == 1, "R4 no key refused", st, 1);
        unlock(32'h524F434A);
        do_write(9'h140, 4, st, cyc);
        chk(st == 1, "R4 wrong key refused", st, 1);
        unlock(KEY);
        do_write(9'h141, 4, st, cyc);
        chk(st == 2, "R5 misaligned offset", st, 2);
        do_write(9'h140, 4, st, cyc);
        chk(st == 1, "R4 key is one-shot", st, 1);
        unlock(KEY);
        do_write(9'h1EC, 8, st, cyc);
        chk(st == 2, "R5 end past region", st, 2);
        unlock(KEY);
        do_write(9'h0FC, 4, st, cyc);
        chk(st == 2, "R5 start below region", st, 2);
        unlock(KEY);
        do_write(9'h140, 6, st, cyc);
        chk(st == 2, "R5 misaligned length", st, 2);
        unlock(KEY);
        do_write(9'h140, 0, st, cyc);
        chk(st == 2, "R5 zero length", st, 2);
        chk(prog_cnt == p0, "R4 R5 refused writes program nothing", prog_cnt - p0, 0);
    endtask

    task automatic t_protected();
        int st, cyc, p0;
        p0 = prog_cnt;
        unlock(KEY);
        do_write(9'h104, 4, st, cyc);
        chk(st == 3, "R7 word locked by earlier write", st, 3);
        unlock(KEY);
        do_write(9'h1EC, 4, st, cyc);
        chk(st == 3, "R7 word locked by fuse map at start-up", st, 3);
        unlock(KEY);
        do_write(9'h11C, 8, st, cyc);
        chk(st == 3, "R7 partial overlap with locked word", st, 3);
        do_write(9'h104, 4, st, cyc);
        chk(st == 1, "R7 lock check ranks after key check", st, 1);
        unlock(KEY);
        do_write(9'h105, 4, st, cyc);
        chk(st == 2, "R7 range check ranks before lock check", st, 2);
        chk(prog_cnt == p0, "R7 protected writes program nothing", prog_cnt - p0, 0);
    endtask

    task automatic t_reads();
        int v;
        do_read(9'h1FF, v);
        chk(v == 8'h08, "R2 read seeded map byte", v, 8);
        do_read(9'h123, v);
        chk(v == 8'hF0, "R2 read programmed byte", v, 8'hF0);
        do_read(9'h1F8, v);
        chk(v == 8'h03, "R2 read burned map byte", v, 3);
    endtask

    task automatic t_busy_ignore();
        int dones, cyc, v;
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        unlock(KEY);
        @(negedge clk);
        wr_off = 9'h1C0; wr_len = 9'd4; wr_start = 1'b1; rd_start = 1'b1; rd_addr = 9'h100;
        @(negedge clk);
        wr_start = 1'b0; rd_start = 1'b0;
        dones = 0;
        cyc = 0;
        @(negedge clk);
        wr_start = 1'b1; rd_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0; rd_start = 1'b0;
        while (cyc < 3000) begin
            if (done) begin
                dones++;
                chk(status == 3'd0, "R9 surviving command status", int'(status), 0);
            end
            @(negedge clk);
            cyc++;
        end
        chk(dones == 1, "R9 starts while busy ignored", dones, 1);
        chk(fuse[9'h1C3] == 8'h04, "R9 write wins over read", int'(fuse[9'h1C3]), 4);
        do_read(9'h1FE, v);
        chk(v == 8'h01, "R6 map word 48 burned", v, 1);
    endtask

    task automatic t_timeout();
        int st, cyc, v, w;
        wbuf[0] = 8'h11; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h00;
        plat = 3000;
        unlock(KEY);
        do_write(9'h180, 4, st, cyc);
        chk(st == 4, "R8 stuck busy gives timeout", st, 4);
        chk(cyc >= 1000, "R8 timeout not before limit", cyc, 1000);
        w = 0;
        while (mac_pbusy && w < 5000) begin
            @(negedge clk);
            w++;
        end
        plat = 5;
        do_read(9'h1FC, v);
        chk(v == 8'h00, "R8 map not updated after timeout", v, 0);
        do_read(9'h180, v);
        chk(v == 8'h11, "R8 late program landed", v, 8'h11);
    endtask

    initial begin
        t_reset_init();
        t_write_basic();
        t_andnot();
        t_zero_data();
        t_locked_args();
        t_protected();
        t_reads();
        t_busy_ignore();
        t_timeout();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule